// File: doc/BRIEF.md
# Trigger-Driven Slice Readout Buffer

The block keeps a rolling history of per-crossing records. Each record is 209 bits wide and holds a 7-bit crossing number, a 4-bit error field, a 6-bit valid vector and 192 bits of payload. On every crossing strobe the record on the input ports is stored in a circular buffer, and the write pointer then advances.

When a Level-1 accept pulse arrives, the block computes a start address. This address sits a configurable latency behind the current write pointer. The block then copies a window of consecutive past records into an external output FIFO, one record per cycle, using the FIFO's write enable and write data.

Readout holds while the FIFO reports programmable-full. Accepts that arrive while a window is in progress wait in a small queue. Each queued accept keeps the start address it had when it arrived. Accepts that find the queue full are counted in a saturating drop counter.

Top module: `l1a_slice_readout`

## Requirements
- R1: After reset, `fifo_wr_en` is low, `drop_count` is zero and the write pointer is at address 0, so the first record after reset is stored at address 0.
- R2: Each cycle with `bx_sync` high stores `{bx_bcn, bx_err, bx_valid, bx_data}` at the write pointer and then increments the pointer modulo DEPTH. In this packing `bx_bcn` occupies bits 208:202, `bx_err` bits 201:198, `bx_valid` bits 197:192 and `bx_data` bits 191:0. DEPTH must be a power of two.
- R3: An accept captures a start address equal to the write pointer minus `cfg_latency`, modulo DEPTH. The pointer used is its value in the accept cycle, before any increment from a strobe in that same cycle.
- R4: A window reads N records at consecutive addresses, wrapping modulo DEPTH. N is `cfg_slices` taken at the start of the window: 0 gives 1, and any value above 5 gives 5.
- R5: `fifo_wr_en` goes high one cycle after each buffer read, with the record on `fifo_wr_data`. When the block is idle, the FIFO is not full and no accept is queued, the first `fifo_wr_en` is high in the third cycle after the accept cycle.
- R6: While `fifo_prog_full` is high, no new window starts and an open window reads no further record. A read already issued still completes its write.
- R7: Up to 4 accepts wait in a queue. They are served in arrival order, and each uses the start address it captured on arrival.
- R8: An accept that arrives while the queue holds 4 entries, and no entry leaves in that same cycle, is discarded. `drop_count` then increments, saturating at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bx_sync | input | 1 | Crossing strobe: stores the current record |
| bx_bcn | input | 7 | Crossing number field |
| bx_err | input | 4 | Error field |
| bx_valid | input | 6 | Valid vector |
| bx_data | input | 192 | Payload |
| l1a | input | 1 | Level-1 accept pulse |
| cfg_latency | input | log2(DEPTH) | Distance of the window start behind the write pointer |
| cfg_slices | input | 3 | Records per window, clamped to 1..5 |
| fifo_prog_full | input | 1 | Output FIFO programmable-full flag |
| fifo_wr_en | output | 1 | Output FIFO write enable |
| fifo_wr_data | output | 209 | Output FIFO write data |
| drop_count | output | 16 | Count of discarded accepts |

## Verification
The bench builds the block with DEPTH set to 16, so `cfg_latency` is 4 bits wide. With that depth, twenty strobes already wrap the buffer. It also brings latencies near the full depth, and windows that cross address 0, within a few dozen cycles. The queue depth and the slice limit stay at their defaults of 4 and 5. This lets the bench reach queue overflow with six back-to-back accepts, and exercise clamping of `cfg_slices` values of 0 and 7.

// File: rtl/l1a_slice_readout.sv
module l1a_slice_readout #(
  parameter int DEPTH      = 512,
  parameter int BCN_W      = 7,
  parameter int ERR_W      = 4,
  parameter int VLD_W      = 6,
  parameter int DATA_W     = 192,
  parameter int MAX_SLICES = 5,
  parameter int QDEPTH     = 4,
  parameter int DROP_W     = 16,
  parameter int SW         = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bx_sync,
  input  logic [BCN_W-1:0]          bx_bcn,
  input  logic [ERR_W-1:0]          bx_err,
  input  logic [VLD_W-1:0]          bx_valid,
  input  logic [DATA_W-1:0]         bx_data,
  input  logic                      l1a,
  input  logic [$clog2(DEPTH)-1:0]  cfg_latency,
  input  logic [SW-1:0]             cfg_slices,
  input  logic                      fifo_prog_full,
  output logic                      fifo_wr_en,
  output logic [BCN_W+ERR_W+VLD_W+DATA_W-1:0] fifo_wr_data,
  output logic [DROP_W-1:0]         drop_count
);
  localparam int AW    = $clog2(DEPTH);
  localparam int REC_W = BCN_W + ERR_W + VLD_W + DATA_W;
  localparam int QIW   = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int QW    = $clog2(QDEPTH + 1);

  logic [REC_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_addr;
  logic [AW-1:0]    q_addr [QDEPTH];
  logic [QIW-1:0]   q_head, q_tail;
  logic [QW-1:0]    q_cnt;
  logic             busy;
  logic [SW-1:0]    remaining, n_slices;
  logic             pop, push, drop, rd_fire;

  assign pop     = !busy && (q_cnt != '0) && !fifo_prog_full;
  assign push    = l1a && ((q_cnt != QW'(QDEPTH)) || pop);
  assign drop    = l1a && !push;
  assign rd_fire = busy && !fifo_prog_full;

  assign n_slices = (cfg_slices == '0) ? SW'(1) :
                    (cfg_slices > SW'(MAX_SLICES)) ? SW'(MAX_SLICES) : cfg_slices;

  function automatic logic [QIW-1:0] q_next(input logic [QIW-1:0] i);
    return (i == QIW'(QDEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (bx_sync) mem[wr_ptr] <= {bx_bcn, bx_err, bx_valid, bx_data};
    if (rd_fire) fifo_wr_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (push) q_addr[q_tail] <= wr_ptr - cfg_latency;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      q_head     <= '0;
      q_tail     <= '0;
      q_cnt      <= '0;
      busy       <= 1'b0;
      rd_addr    <= '0;
      remaining  <= '0;
      fifo_wr_en <= 1'b0;
      drop_count <= '0;
    end else begin
      fifo_wr_en <= rd_fire;
      if (bx_sync) wr_ptr <= wr_ptr + 1'b1;
      if (push) q_tail <= q_next(q_tail);
      if (pop)  q_head <= q_next(q_head);
      if (push && !pop)      q_cnt <= q_cnt + 1'b1;
      else if (pop && !push) q_cnt <= q_cnt - 1'b1;
      if (drop && (drop_count != '1)) drop_count <= drop_count + 1'b1;
      if (pop) begin
        busy      <= 1'b1;
        rd_addr   <= q_addr[q_head];
        remaining <= n_slices;
      end else if (rd_fire) begin
        rd_addr   <= rd_addr + 1'b1;
        remaining <= remaining - 1'b1;
        if (remaining == SW'(1)) busy <= 1'b0;
      end
    end
  end
endmodule

module l1a_slice_readout_chk #(
  parameter int AW = 9, QW = 3, SW = 3, DROP_W = 16, QDEPTH = 4, MAX_SLICES = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bx_sync,
  input logic              l1a,
  input logic              fifo_prog_full,
  input logic              busy,
  input logic              pop,
  input logic [QW-1:0]     q_cnt,
  input logic [AW-1:0]     rd_addr,
  input logic [AW-1:0]     wr_ptr,
  input logic [SW-1:0]     remaining,
  input logic [DROP_W-1:0] drop_count
);
  a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    bx_sync |=> wr_ptr == $past(wr_ptr) + 1'b1);
  a_r4_slice_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (remaining >= SW'(1)) && (remaining <= SW'(MAX_SLICES)));
  a_r6_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && fifo_prog_full) |=> !busy);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fifo_prog_full) |=> $stable(rd_addr) && $stable(remaining));
  a_r7_queue_bound: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= QW'(QDEPTH));
  a_r8_drop_count: assert property (@(posedge clk) disable iff (!rst_n)
    (l1a && q_cnt == QW'(QDEPTH) && !pop && drop_count != '1)
      |=> drop_count == $past(drop_count) + 1'b1);
endmodule

bind l1a_slice_readout l1a_slice_readout_chk #(
  .AW(AW), .QW(QW), .SW(SW), .DROP_W(DROP_W), .QDEPTH(QDEPTH), .MAX_SLICES(MAX_SLICES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bx_sync(bx_sync), .l1a(l1a),
  .fifo_prog_full(fifo_prog_full), .busy(busy), .pop(pop), .q_cnt(q_cnt),
  .rd_addr(rd_addr), .wr_ptr(wr_ptr), .remaining(remaining), .drop_count(drop_count)
);

// File: tb/sim_l1a_slice_readout.sv
module sim_l1a_slice_readout;
  localparam int D = 16;
  localparam int RW = 209;

  logic clk = 0, rst_n = 0, bx_sync = 0, l1a = 0, pfull = 0;
  logic [6:0] bcn = 0; logic [3:0] err = 0; logic [5:0] vld = 0; logic [191:0] dat = 0;
  logic [3:0] lat = 0; logic [2:0] nsl = 1;
  logic wr_en; logic [RW-1:0] wr_data; logic [15:0] drops;

  int checks = 0, fails = 0, gwr = 0, ncap = 0;
  logic [RW-1:0] cap [256];

  always #10 clk = ~clk;

  l1a_slice_readout #(.DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .bx_sync(bx_sync), .bx_bcn(bcn), .bx_err(err),
    .bx_valid(vld), .bx_data(dat), .l1a(l1a), .cfg_latency(lat), .cfg_slices(nsl),
    .fifo_prog_full(pfull), .fifo_wr_en(wr_en), .fifo_wr_data(wr_data), .drop_count(drops));

  localparam int VEC [7][2] = '{'{1,1}, '{3,2}, '{5,5}, '{0,3}, '{15,4}, '{2,7}, '{4,0}};

  function automatic logic [RW-1:0] rec(input int i);
    logic [31:0] w = 32'hC0DE0000 ^ (i * 32'h9E37);
    return {7'(i), 4'(i) ^ 4'h5, 6'(i) ^ 6'h2A, {6{w}}};
  endfunction

  function automatic int clampn(input int n);
    return (n == 0) ? 1 : (n > 5) ? 5 : n;
  endfunction

  function automatic logic [RW-1:0] expect_rec(input int g, input int l, input int k, input int gnow);
    int a = ((g - l + k) % D + D) % D;
    int off = ((gnow - a) % D + D) % D;
    if (off == 0) off = D;
    return rec(gnow - off);
  endfunction

  task automatic step();
    @(negedge clk);
    if (wr_en) begin cap[ncap] = wr_data; ncap++; end
  endtask

  task automatic chk(input logic ok, input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) begin
      bx_sync = 1; {bcn, err, vld, dat} = rec(gwr);
      step(); gwr++;
    end
    bx_sync = 0;
  endtask

  task automatic pulse();
    l1a = 1; step(); l1a = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int base, g1;
    step(); step(); rst_n = 1; step();
    chk(wr_en == 0, "R1 wr_en after reset", RW'(wr_en), 0);
    chk(drops == 0, "R1 drop_count after reset", RW'(drops), 0);

    // R1: first three records land at addresses 0..2
    fill(3); lat = 3; nsl = 3; base = ncap;
    pulse(); repeat (8) step();
    chk(ncap - base == 3, "R1 window size", RW'(ncap - base), 3);
    for (int k = 0; k < 3; k++) chk(cap[base + k] === rec(k), "R1 start at address 0", cap[base + k], rec(k));

    // vector table: R2 R3 R4 across latencies and slice counts
    foreach (VEC[v]) begin
      fill(20); lat = 4'(VEC[v][0]); nsl = 3'(VEC[v][1]); base = ncap; g1 = gwr;
      pulse(); repeat (12) step();
      chk(ncap - base == clampn(VEC[v][1]), "R4 slice count", RW'(ncap - base), RW'(clampn(VEC[v][1])));
      for (int k = 0; k < clampn(VEC[v][1]); k++)
        chk(cap[base + k] === expect_rec(g1, VEC[v][0], k, gwr), "R2 R3 record content",
            cap[base + k], expect_rec(g1, VEC[v][0], k, gwr));
    end

    // R5: first write in third cycle after accept
    lat = 2; nsl = 1; base = ncap;
    l1a = 1; step(); l1a = 0;
    step(); chk(ncap == base, "R5 no write one cycle early", RW'(ncap - base), 0);
    step(); chk(ncap == base + 1, "R5 write on third cycle", RW'(ncap - base), 1);
    repeat (4) step();

    // R6: no start while prog-full
    pfull = 1; nsl = 2; base = ncap; g1 = gwr;
    pulse(); repeat (8) step();
    chk(ncap == base, "R6 no start while full", RW'(ncap - base), 0);
    pfull = 0; repeat (8) step();
    chk(ncap == base + 2, "R6 resumes after full", RW'(ncap - base), 2);

    // R6: pause mid-window
    nsl = 5; lat = 6; base = ncap; g1 = gwr;
    pulse();
    while (ncap == base) step();
    pfull = 1; repeat (6) step();
    chk(ncap == base + 1, "R6 pause between slices", RW'(ncap - base), 1);
    pfull = 0; repeat (10) step();
    chk(ncap == base + 5, "R6 window completes", RW'(ncap - base), 5);
    for (int k = 0; k < 5; k++)
      chk(cap[base + k] === expect_rec(g1, 6, k, gwr), "R6 paused window order",
          cap[base + k], expect_rec(g1, 6, k, gwr));

    // R7 R8: queue of 4, overflow drops, own start addresses
    pfull = 1; nsl = 2; lat = 2; base = ncap;
    g1 = gwr; pulse();
    fill(1);
    for (int i = 0; i < 5; i++) pulse();
    step();
    chk(drops == 2, "R8 dropped accepts", RW'(drops), 2);
    pfull = 0; repeat (30) step();
    chk(ncap - base == 8, "R7 four queued windows", RW'(ncap - base), 8);
    for (int w = 0; w < 4; w++)
      for (int k = 0; k < 2; k++)
        chk(cap[base + 2*w + k] === expect_rec((w == 0) ? g1 : g1 + 1, 2, k, gwr),
            "R7 queued start address", cap[base + 2*w + k],
            expect_rec((w == 0) ? g1 : g1 + 1, 2, k, gwr));

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule